// File: doc/BRIEF.md
# Event Counter Bank with Global Gating

This block keeps a set of event counters for a processor core. Two kinds of counter sit side by side. Each general-purpose counter has its own 32-bit event-select word that chooses privilege qualification, a threshold compare, inversion, edge detection and interrupt behaviour. Each fixed counter is configured by a 4-bit field inside one shared fixed-control word. Every counter receives a per-cycle count of qualifying occurrences from outside. A single privilege input tells the bank whether the core is in user or supervisor mode.

A counter only advances when its own enable and its bit in the global enable word are both set. When a counter passes its all-ones value it continues from zero, sets its bit in a shared wrap status word, and, if that counter asks for it, pulses the interrupt request for one cycle. Software clears status bits by writing ones to a clear word. All configuration and readback go through one address/data port: writes take effect on the clock edge, reads are combinational from the address.

Register addresses (6-bit): general-purpose counter n at 0x00+n, its select word at 0x10+n, fixed counter n at 0x20+n, fixed-control word at 0x30, global enable at 0x31, wrap status at 0x32 (read only), status clear at 0x33 (write only, reads zero).

Top module: `pmc_bank`

## Requirements
- R1: A select word keeps all 32 written bits and reads them back zero-extended; its fields are event code 7:0, unit mask 15:8, user enable 16, supervisor enable 17, edge 18, pin control 19, interrupt enable 20, local enable 22, invert 23 and threshold 31:24.
- R2: A counter stays frozen whenever its local enable is clear or its global enable bit is clear, even with events present.
- R3: In the global enable and wrap status words, general-purpose counter n is bit n and fixed counter n is bit 32+n; the global word reads back only those implemented bits.
- R4: Fixed counter n uses fixed-control bits 4n+3:4n, where field bit 0 enables supervisor counting, bit 1 user counting and bit 3 the wrap interrupt; an all-zero field keeps the counter frozen.
- R5: A counter passing its maximum wraps and keeps counting from zero, and its status bit is set; a counter preloaded to the maximum reads 1 after two further events.
- R6: Writing ones to the clear word clears the matching status bits; zero bits in that write leave status unchanged.
- R7: A wrap pulses the interrupt output high for exactly one cycle only when that counter's interrupt enable is set; without it only the status bit is set.
- R8: With a nonzero threshold, a general-purpose counter adds one in each cycle whose event count is at least the threshold, so it counts less than with a zero threshold.
- R9: With invert set and a nonzero threshold, the comparison becomes event count below the threshold.
- R10: With edge set and a nonzero threshold, the counter adds one only when the comparison goes from false to true.
- R11: With a zero threshold the counter adds the full per-cycle event count; counting needs the user enable when the privilege input is 1 (user) and the supervisor enable when it is 0.
- R12: After reset all counters, select words, the fixed-control word, the global enable and the status read zero, at the addresses listed above; counters read back 48 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gp_evt | input | NUM_GP*EVT_W | Per-cycle event counts, counter n in bits n*EVT_W upward |
| fix_evt | input | NUM_FIX*EVT_W | Per-cycle event counts for fixed counters |
| priv_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr |
| irq | output | 1 | One-cycle interrupt request on an enabled wrap |

## Verification
The bench builds the bank with its defaults: four general-purpose and three fixed counters, 48-bit counters and 4-bit event counts. Wraps of the 48-bit counters come within reach by preloading values near the maximum through the register port, and the 4-bit event counts let a threshold of two split short event sequences into counted and uncounted cycles for the threshold, invert and edge modes. The fixed counter at index one lands on status bit 33, which checks that the upper half of the shared status and enable words is mapped.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef struct packed {
    logic [7:0] thr;
    logic       inv;
    logic       en;
    logic       rsv;
    logic       intr;
    logic       pin;
    logic       edg;
    logic       os;
    logic       usr;
    logic [7:0] umask;
    logic [7:0] code;
  } evsel_t;

  localparam int STS_W    = 64;
  localparam int FIX_BASE = 32;

  // privilege qualification: user mode needs usr_en, supervisor needs os_en
  function automatic logic priv_ok(input logic user, input logic usr_en, input logic os_en);
    return user ? usr_en : os_en;
  endfunction

  // threshold comparison, flipped by invert
  function automatic logic thr_hit(input logic [7:0] evt, input logic [7:0] thr, input logic inv);
    return inv ? (evt < thr) : (evt >= thr);
  endfunction

  // per-cycle increment of a general-purpose counter
  function automatic logic [7:0] gp_step(input logic [7:0] evt, input logic [7:0] thr,
                                         input logic edg, input logic hit, input logic hit_prev);
    if (thr == 8'd0) return evt;
    if (edg) return {7'd0, hit & ~hit_prev};
    return {7'd0, hit};
  endfunction

endpackage

// File: rtl/pmc_gp_counter.sv
module pmc_gp_counter
  import pmc_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_loc,
  input  logic             usr_en,
  input  logic             os_en,
  input  logic             edg,
  input  logic             inv,
  input  logic             intr,
  input  logic [7:0]       thr,
  input  logic             glb_en,
  input  logic             priv_user,
  input  logic [EVT_W-1:0] evt,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             irq_req
);

  logic [CNT_W-1:0] cnt_q;
  logic             hit_q;
  logic [7:0]       evt8;
  logic             hit;
  logic [7:0]       incr;
  logic             active;
  logic [CNT_W:0]   sum;

  assign evt8    = 8'(evt);
  assign hit     = thr_hit(evt8, thr, inv);
  assign incr    = gp_step(evt8, thr, edg, hit, hit_q);
  assign active  = en_loc & glb_en & priv_ok(priv_user, usr_en, os_en);
  assign sum     = {1'b0, cnt_q} + (CNT_W+1)'(incr);
  assign wrap    = active & sum[CNT_W] & ~wr_cnt;
  assign irq_req = wrap & intr;
  assign cnt     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit;
      if (wr_cnt)      cnt_q <= wr_val;
      else if (active) cnt_q <= sum[CNT_W-1:0];
    end
  end

  AST_GP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !wr_cnt) |=> $stable(cnt_q)); // R2

  AST_GP_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q < CNT_W'(256))); // R5

  AST_GP_EDGE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && edg && thr != 8'd0 && !wr_cnt) |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(1))); // R10

endmodule

// File: rtl/pmc_fix_counter.sv
module pmc_fix_counter
  import pmc_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usr_en,
  input  logic             os_en,
  input  logic             intr,
  input  logic             glb_en,
  input  logic             priv_user,
  input  logic [EVT_W-1:0] evt,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             irq_req
);

  logic [CNT_W-1:0] cnt_q;
  logic             active;
  logic [CNT_W:0]   sum;

  assign active  = glb_en & priv_ok(priv_user, usr_en, os_en);
  assign sum     = {1'b0, cnt_q} + (CNT_W+1)'(evt);
  assign wrap    = active & sum[CNT_W] & ~wr_cnt;
  assign irq_req = wrap & intr;
  assign cnt     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wr_val;
    else if (active) cnt_q <= sum[CNT_W-1:0];
  end

  AST_FIX_FIELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!usr_en && !os_en && !wr_cnt) |=> $stable(cnt_q)); // R4

  AST_FIX_GLB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !wr_cnt) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/pmc_wrap_status.sv
module pmc_wrap_status
  import pmc_pkg::*;
#(
  parameter int W = STS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wrap_vec,
  input  logic [W-1:0] int_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status,
  output logic         irq
);

  logic [W-1:0] status_q;
  logic         irq_q;
  logic [W-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;
  assign status  = status_q;
  assign irq     = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_eff) | wrap_vec;
      irq_q    <= |int_vec;
    end
  end

  AST_STS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_vec) |=> ((status_q & $past(wrap_vec)) == $past(wrap_vec))); // R5

  AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((status_q & $past(clr_mask & ~wrap_vec)) == '0)); // R6

  AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((status_q & $past(status_q)) == $past(status_q))); // R6

  AST_IRQ_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (status_q != '0)); // R7

endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FIX = 3,
  parameter int CNT_W   = 48,
  parameter int EVT_W   = 4,
  parameter int ADDR_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_GP*EVT_W-1:0]  gp_evt,
  input  logic [NUM_FIX*EVT_W-1:0] fix_evt,
  input  logic                     priv_user,
  input  logic                     reg_wr,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [63:0]              reg_wdata,
  output logic [63:0]              reg_rdata,
  output logic                     irq
);

  localparam int A_GP   = 'h00;
  localparam int A_SEL  = 'h10;
  localparam int A_FIX  = 'h20;
  localparam int A_FCTL = 'h30;
  localparam int A_GLB  = 'h31;
  localparam int A_STS  = 'h32;
  localparam int A_CLR  = 'h33;
  localparam int FCTL_W = 4 * NUM_FIX;
  localparam logic [STS_W-1:0] VALID =
    ((STS_W'(1) << NUM_GP) - STS_W'(1)) |
    (((STS_W'(1) << NUM_FIX) - STS_W'(1)) << FIX_BASE);

  evsel_t            sel_q  [NUM_GP];
  logic [FCTL_W-1:0] fctl_q;
  logic [STS_W-1:0]  glb_q;
  logic [CNT_W-1:0]  gp_cnt [NUM_GP];
  logic [CNT_W-1:0]  fix_cnt[NUM_FIX];
  logic [NUM_GP-1:0] gp_wrap, gp_irq;
  logic [NUM_FIX-1:0] fix_wrap, fix_irq;
  logic [STS_W-1:0]  wrap_vec, int_vec, status;
  logic              clr_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fctl_q <= '0;
      glb_q  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_W'(A_FCTL)) fctl_q <= reg_wdata[FCTL_W-1:0];
      if (reg_addr == ADDR_W'(A_GLB))  glb_q  <= reg_wdata & VALID;
    end
  end

  assign clr_we = reg_wr && (reg_addr == ADDR_W'(A_CLR));

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q[g] <= '0;
      else if (reg_wr && reg_addr == ADDR_W'(A_SEL + g)) sel_q[g] <= evsel_t'(reg_wdata[31:0]);
    end

    pmc_gp_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_loc   (sel_q[g].en),
      .usr_en   (sel_q[g].usr),
      .os_en    (sel_q[g].os),
      .edg      (sel_q[g].edg),
      .inv      (sel_q[g].inv),
      .intr     (sel_q[g].intr),
      .thr      (sel_q[g].thr),
      .glb_en   (glb_q[g]),
      .priv_user(priv_user),
      .evt      (gp_evt[g*EVT_W +: EVT_W]),
      .wr_cnt   (reg_wr && reg_addr == ADDR_W'(A_GP + g)),
      .wr_val   (reg_wdata[CNT_W-1:0]),
      .cnt      (gp_cnt[g]),
      .wrap     (gp_wrap[g]),
      .irq_req  (gp_irq[g])
    );
  end

  for (genvar f = 0; f < NUM_FIX; f++) begin : g_fix
    pmc_fix_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .usr_en   (fctl_q[4*f+1]),
      .os_en    (fctl_q[4*f]),
      .intr     (fctl_q[4*f+3]),
      .glb_en   (glb_q[FIX_BASE+f]),
      .priv_user(priv_user),
      .evt      (fix_evt[f*EVT_W +: EVT_W]),
      .wr_cnt   (reg_wr && reg_addr == ADDR_W'(A_FIX + f)),
      .wr_val   (reg_wdata[CNT_W-1:0]),
      .cnt      (fix_cnt[f]),
      .wrap     (fix_wrap[f]),
      .irq_req  (fix_irq[f])
    );
  end

  always_comb begin
    wrap_vec = '0;
    int_vec  = '0;
    for (int i = 0; i < NUM_GP; i++) begin
      wrap_vec[i] = gp_wrap[i];
      int_vec[i]  = gp_irq[i];
    end
    for (int i = 0; i < NUM_FIX; i++) begin
      wrap_vec[FIX_BASE+i] = fix_wrap[i];
      int_vec[FIX_BASE+i]  = fix_irq[i];
    end
  end

  pmc_wrap_status #(.W(STS_W)) i_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrap_vec(wrap_vec),
    .int_vec (int_vec),
    .clr_we  (clr_we),
    .clr_mask(reg_wdata),
    .status  (status),
    .irq     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_GP; i++) begin
      if (reg_addr == ADDR_W'(A_GP + i))  reg_rdata = 64'(gp_cnt[i]);
      if (reg_addr == ADDR_W'(A_SEL + i)) reg_rdata = 64'(sel_q[i]);
    end
    for (int i = 0; i < NUM_FIX; i++)
      if (reg_addr == ADDR_W'(A_FIX + i)) reg_rdata = 64'(fix_cnt[i]);
    if (reg_addr == ADDR_W'(A_FCTL)) reg_rdata = 64'(fctl_q);
    if (reg_addr == ADDR_W'(A_GLB))  reg_rdata = glb_q;
    if (reg_addr == ADDR_W'(A_STS))  reg_rdata = status;
  end

  AST_STATUS_IMPLEMENTED: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~VALID) == '0); // R3

  AST_GP_WRAP_NEEDS_GLB: assert property (@(posedge clk) disable iff (!rst_n)
    (|(wrap_vec & ~glb_q)) == 1'b0); // R2

endmodule

// File: tb/test_pmc_bank.sv
module test_pmc_bank;

  localparam logic [63:0] MAX   = 64'h0000_FFFF_FFFF_FFFF;
  localparam logic [5:0] A_SEL  = 6'h10, A_FIX = 6'h20, A_FCTL = 6'h30;
  localparam logic [5:0] A_GLB  = 6'h31, A_STS = 6'h32, A_CLR = 6'h33;
  localparam logic [63:0] B_USR = 64'h1_0000, B_OS = 64'h2_0000, B_EDGE = 64'h4_0000;
  localparam logic [63:0] B_INT = 64'h10_0000, B_EN = 64'h40_0000, B_INV = 64'h80_0000;
  localparam logic [63:0] THR2  = 64'h0200_0000;
  localparam logic [63:0] GLB_ALL = 64'h7_0000_000F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  g0 = '0, g1 = '0, g2 = '0, g3 = '0, f0 = '0, f1 = '0, f2 = '0;
  logic        priv_user = 1'b1;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        irq;
  int          total = 0, failed = 0, irq_seen = 0, irq_base;

  typedef struct {
    logic [5:0]  addr;
    logic [63:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #4 clk = ~clk;

  pmc_bank i_pmc_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .gp_evt   ({g3, g2, g1, g0}),
    .fix_evt  ({f2, f1, f0}),
    .priv_user(priv_user),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq      (irq)
  );

  // monitor: pops expected reads and compares them mid-cycle
  always @(negedge clk) begin
    if (irq) irq_seen++;
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      total++;
      if (reg_rdata !== it.exp) begin
        failed++;
        $display("FAIL %s: addr %h got %h expected %h", it.tag, it.addr, reg_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  // driver: pushes the expected read value for the monitor
  task automatic chk(input logic [5:0] a, input logic [63:0] e, input string tag);
    sb_item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    reg_addr = a;
    sb_q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic chk_val(input int act, input int e, input string tag);
    total++;
    if (act != e) begin
      failed++;
      $display("FAIL %s: got %0d expected %0d", tag, act, e);
    end
  endtask

  task automatic step(input logic [3:0] a0, a1, a2, a3, b0, b1, b2, input logic u);
    g0 = a0; g1 = a1; g2 = a2; g3 = a3; f0 = b0; f1 = b1; f2 = b2; priv_user = u;
    @(posedge clk); #1;
    g0 = 0; g1 = 0; g2 = 0; g3 = 0; f0 = 0; f1 = 0; f2 = 0; priv_user = 1'b1;
  endtask

  task automatic seq_gp(input int idx, input logic [3:0] v, input logic u);
    g0 = 0; g1 = 0; g2 = 0; g3 = 0; priv_user = u;
    case (idx)
      0: g0 = v;
      1: g1 = v;
      2: g2 = v;
      default: g3 = v;
    endcase
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R12: reset state
    chk(6'h00, 64'd0, "R12");
    chk(A_SEL, 64'd0, "R12");
    chk(A_GLB, 64'd0, "R12");
    chk(A_STS, 64'd0, "R12");

    wr(A_SEL + 0, B_EN | B_USR | B_OS);
    wr(A_SEL + 1, B_EN | B_OS);
    wr(A_SEL + 2, B_EN | B_USR | B_OS | THR2);
    wr(A_SEL + 3, B_EN | B_OS | B_INV | THR2);
    wr(A_GLB, GLB_ALL);

    // R11: zero threshold adds full count
    for (int i = 0; i < 5; i++) step(3, 0, 0, 0, 0, 0, 0, 1'b1);
    chk(6'h00, 64'd15, "R11");

    // R11: supervisor-only counter ignores user mode
    for (int i = 0; i < 4; i++) step(0, 2, 0, 3, 0, 0, 0, 1'b1);
    chk(6'h01, 64'd0, "R11");
    for (int i = 0; i < 4; i++) step(0, 2, 0, 3, 0, 0, 0, 1'b0);
    chk(6'h01, 64'd8, "R11");

    // R2: global bit clear, then local enable clear
    wr(A_GLB, GLB_ALL & ~64'h1);
    for (int i = 0; i < 5; i++) step(3, 0, 0, 0, 0, 0, 0, 1'b1);
    chk(6'h00, 64'd15, "R2");
    wr(A_GLB, GLB_ALL);
    wr(A_SEL + 0, B_USR | B_OS);
    for (int i = 0; i < 5; i++) step(3, 0, 0, 0, 0, 0, 0, 1'b1);
    chk(6'h00, 64'd15, "R2");
    wr(A_SEL + 0, B_EN | B_USR | B_OS);

    // R8: threshold 2, stream 1,2,3,0,4
    seq_gp(2, 1, 1'b1); seq_gp(2, 2, 1'b1); seq_gp(2, 3, 1'b1);
    seq_gp(2, 0, 1'b1); seq_gp(2, 4, 1'b1);
    step(0, 0, 0, 0, 0, 0, 0, 1'b1);
    chk(6'h02, 64'd3, "R8");

    // R9: inverted threshold, supervisor mode
    seq_gp(3, 1, 1'b0); seq_gp(3, 2, 1'b0); seq_gp(3, 3, 1'b0);
    seq_gp(3, 0, 1'b0); seq_gp(3, 4, 1'b0);
    step(0, 0, 0, 0, 0, 0, 0, 1'b1);
    chk(6'h03, 64'd2, "R9");

    // R10: edge mode, stream 3,3,0,2,5,1,4 -> three rising edges
    wr(A_SEL + 2, B_EN | B_USR | B_OS | B_EDGE | THR2);
    wr(6'h02, 64'd0);
    seq_gp(2, 3, 1'b1); seq_gp(2, 3, 1'b1); seq_gp(2, 0, 1'b1); seq_gp(2, 2, 1'b1);
    seq_gp(2, 5, 1'b1); seq_gp(2, 1, 1'b1); seq_gp(2, 4, 1'b1);
    step(0, 0, 0, 0, 0, 0, 0, 1'b1);
    chk(6'h02, 64'd3, "R10");

    // R5 / R7: wrap without interrupt enable
    wr(A_CLR, {64{1'b1}});
    wr(6'h00, MAX);
    irq_base = irq_seen;
    step(2, 0, 0, 0, 0, 0, 0, 1'b1);
    chk(6'h00, 64'd1, "R5");
    chk(A_STS, 64'h1, "R5");
    chk_val(irq_seen - irq_base, 0, "R7");

    // R6: zero bits leave status, one bits clear it
    wr(A_CLR, 64'd0);
    chk(A_STS, 64'h1, "R6");
    wr(A_CLR, 64'h1);
    chk(A_STS, 64'd0, "R6");

    // R4 / R3 / R7: fixed counter 1 with interrupt, status bit 33
    wr(A_FCTL, 64'h2B0);
    wr(A_FIX + 1, MAX);
    irq_base = irq_seen;
    step(0, 0, 0, 0, 0, 1, 0, 1'b1);
    chk(A_FIX + 1, 64'd0, "R4");
    chk(A_STS, 64'h2_0000_0000, "R3");
    chk_val(irq_seen - irq_base, 1, "R7");

    // R4: zero field frozen, user-only field
    step(0, 0, 0, 0, 5, 0, 4, 1'b1);
    step(0, 0, 0, 3, 0, 0, 4, 1'b0);
    chk(A_FIX + 0, 64'd0, "R4");
    chk(A_FIX + 2, 64'd4, "R4");

    // R7: general-purpose wrap with interrupt enable, supervisor mode
    wr(A_SEL + 1, B_EN | B_OS | B_INT);
    wr(6'h01, MAX - 64'd1);
    irq_base = irq_seen;
    step(0, 3, 0, 3, 0, 0, 0, 1'b0);
    chk(6'h01, 64'd1, "R5");
    chk(A_STS, 64'h2_0000_0002, "R7");
    chk_val(irq_seen - irq_base, 1, "R7");

    // R1 / R3 / R12: readback widths
    wr(A_SEL + 3, 64'hFFFF_FFFF_ABCD_1234);
    chk(A_SEL + 3, 64'h0000_0000_ABCD_1234, "R1");
    wr(A_GLB, {64{1'b1}});
    chk(A_GLB, GLB_ALL, "R3");
    wr(6'h02, {64{1'b1}});
    chk(6'h02, MAX, "R12");
    chk(A_CLR, 64'd0, "R12");

    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule